// File: doc/BRIEF.md
# Dual-Window Sequential Address Pointer

This block produces the running address for sequential access to an 8K-word memory. A 13-bit pointer advances once per clock while the active-low count enable is low. Two address windows are programmable, each with its own start and end address. Each window has a 2-bit policy that sets what happens when the pointer reaches that window's end: jump to the other window's start, freeze the pointer and block sequential writes, keep counting, or keep counting with the end output silenced.

A sticky flag per window records that its end was reached. Software clears a flag by writing 0 to its bit; writing 1 leaves it as it is. Each active-low end output shows its flag unless that window is in the silenced policy. A frozen pointer is released by writing 0 to the release bit of the policy register, by a pointer load, by either window-start strobe, or by reset. All register writes and releases take effect on the clock.

Top module: `seq_ptr_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the pointer becomes 0, both flags clear, both policies become linear (policy register reads 0x00A), `wr_inhibit` goes low, both start addresses become 0 and both end addresses become 0x1FFF.
- R2: At a clock edge with `cnt_en_n` low and no end action, the pointer adds one and wraps from 0x1FFF to 0. With `cnt_en_n` high and no load or start strobe, the pointer holds.
- R3: `ld` puts `ld_addr` into the pointer at the next edge whatever `cnt_en_n` is. `strt1` loads the window-1 start and `strt2` loads the window-2 start. When more than one is high, `ld` wins over `strt1`, and `strt1` wins over `strt2`.
- R4: With `reg_we` high, `reg_sel` picks the register written from `reg_wdata`, and `reg_rdata` shows the selected register at once. The codes are: 0 window-1 start, 1 window-1 end, 2 window-2 start, 3 window-2 end, 4 policy, 5 flags. Codes 6 and 7 read 0. In the policy register, bits 1:0 are the window-1 policy, bits 3:2 are the window-2 policy, and bit 4 reads 1 while the pointer is frozen.
- R5: At every edge where the pointer equals a window's end address, that window's flag is set: flag-register bit 0 for window 1 and bit 1 for window 2. A set flag stays set until it is cleared.
- R6: A write to register 5 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1. If a window's end is hit at the same edge, that flag is set.
- R7: `eob1_n` and `eob2_n` are low exactly when their flag is set and their policy is not mask (11).
- R8: Chaining (00) applies at an enabled edge where the pointer is at a window's end. At window 1's end the pointer loads window 2's start, and at window 2's end it loads window 1's start. When both windows chain and both ends match, it loads window 1's start.
- R9: Stop (01): at an edge where the pointer is at the end of a stop-policy window, the pointer freezes and `wr_inhibit` goes high. The frozen value is end+1 if `cnt_en_n` is low at that edge, otherwise it is the end address. It then holds regardless of `cnt_en_n`.
- R10: Writing register 4 with bit 4 = 0 while frozen arms a release. At the next edge, if `cnt_en_n` is low, the pointer leaves the freeze and adds one (end+2 after a freeze at end+1). If `cnt_en_n` is high, the pointer stays frozen and the release is used up. A write with bit 4 = 1 does not release. `ld`, `strt1` and `strt2` release at once.
- R11: Linear (10) and mask (11) keep the pointer counting through the end address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en_n | input | 1 | Count enable, active low |
| ld | input | 1 | Load the pointer from `ld_addr` |
| ld_addr | input | 13 | Pointer load value |
| strt1 | input | 1 | Jump to the window-1 start |
| strt2 | input | 1 | Jump to the window-2 start |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 13 | Register write data |
| reg_rdata | output | 13 | Selected register contents |
| ptr | output | 13 | Current pointer |
| eob1_n | output | 1 | Window-1 end indication, active low |
| eob2_n | output | 1 | Window-2 end indication, active low |
| wr_inhibit | output | 1 | High while the pointer is frozen |

## Verification
The hardest states to reach are the two release outcomes after a freeze. The bench first drives the pointer into a stop-policy end with count enable both low and high, so it freezes at end+1 and at the end address. It then issues the release write once with the enable high, where the freeze must survive and the release must be used up, and once with the enable low, where the pointer must step to end+2. Equal end addresses under chaining are set up by rewriting one end to match the other, so both flags fire at the same edge and the jump must go to window 1.

// File: rtl/seq_ptr_pkg.sv
package seq_ptr_pkg;
    localparam int NBUF    = 2;
    localparam int POL_W   = 2;
    localparam int SEL_W   = 3;
    localparam int REL_BIT = 4;

    typedef enum logic [POL_W-1:0] {
        POL_CHAIN  = 2'b00,
        POL_STOP   = 2'b01,
        POL_LINEAR = 2'b10,
        POL_MASK   = 2'b11
    } eob_pol_e;

    localparam logic [SEL_W-1:0] SEL_START1 = 3'd0;
    localparam logic [SEL_W-1:0] SEL_END1   = 3'd1;
    localparam logic [SEL_W-1:0] SEL_START2 = 3'd2;
    localparam logic [SEL_W-1:0] SEL_END2   = 3'd3;
    localparam logic [SEL_W-1:0] SEL_FLOW   = 3'd4;
    localparam logic [SEL_W-1:0] SEL_FLAG   = 3'd5;
endpackage

// File: rtl/seq_ptr_regs.sv
module seq_ptr_regs
    import seq_ptr_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             reg_we,
    input  logic [SEL_W-1:0]                 reg_sel,
    input  logic [ADDR_W-1:0]                reg_wdata,
    output logic [NBUF-1:0][ADDR_W-1:0]      win_start,
    output logic [NBUF-1:0][ADDR_W-1:0]      win_end,
    output logic [NBUF-1:0][POL_W-1:0]       pol,
    output logic [NBUF-1:0]                  flag_keep,
    output logic                             rel_req
);
    typedef struct packed {
        logic [NBUF-1:0][ADDR_W-1:0] start;
        logic [NBUF-1:0][ADDR_W-1:0] fin;
        logic [NBUF-1:0][POL_W-1:0]  pol;
    } regs_t;

    regs_t r_d, r_q;

    logic win_hit;
    logic flow_hit;
    logic flag_hit;

    assign win_hit  = reg_we && (reg_sel < SEL_FLOW);
    assign flow_hit = reg_we && (reg_sel == SEL_FLOW);
    assign flag_hit = reg_we && (reg_sel == SEL_FLAG);

    always_comb begin
        r_d = r_q;
        if (win_hit) begin
            if (reg_sel[0]) begin
                r_d.fin[reg_sel[1]] = reg_wdata;
            end else begin
                r_d.start[reg_sel[1]] = reg_wdata;
            end
        end
        if (flow_hit) begin
            for (int b = 0; b < NBUF; b++) begin
                r_d.pol[b] = reg_wdata[b*POL_W +: POL_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.start <= '0;
            r_q.fin   <= '1;
            for (int b = 0; b < NBUF; b++) begin
                r_q.pol[b] <= POL_LINEAR;
            end
        end else begin
            r_q <= r_d;
        end
    end

    generate
        for (genvar g = 0; g < NBUF; g++) begin : g_keep
            assign flag_keep[g] = flag_hit ? reg_wdata[g] : 1'b1;
        end
    endgenerate

    assign rel_req   = flow_hit && !reg_wdata[REL_BIT];
    assign win_start = r_q.start;
    assign win_end   = r_q.fin;
    assign pol       = r_q.pol;
endmodule

// File: rtl/seq_ptr_core.sv
module seq_ptr_core
    import seq_ptr_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cnt_en_n,
    input  logic                        ld,
    input  logic [ADDR_W-1:0]           ld_addr,
    input  logic                        strt1,
    input  logic                        strt2,
    input  logic [NBUF-1:0][ADDR_W-1:0] win_start,
    input  logic [NBUF-1:0][ADDR_W-1:0] win_end,
    input  logic [NBUF-1:0][POL_W-1:0]  pol,
    input  logic [NBUF-1:0]             flag_keep,
    input  logic                        rel_req,
    output logic [ADDR_W-1:0]           ptr,
    output logic [NBUF-1:0]             flags,
    output logic                        stopped
);
    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic [NBUF-1:0]   flags;
        logic              stopped;
        logic              arm;
    } core_t;

    core_t c_d, c_q;

    logic [NBUF-1:0] hit;
    logic [NBUF-1:0] chain_hit;
    logic [NBUF-1:0] stop_hit;
    logic [ADDR_W-1:0] ptr_inc;
    logic en;

    generate
        for (genvar g = 0; g < NBUF; g++) begin : g_match
            assign hit[g]       = (c_q.ptr == win_end[g]);
            assign chain_hit[g] = hit[g] && (pol[g] == POL_CHAIN);
            assign stop_hit[g]  = hit[g] && (pol[g] == POL_STOP);
        end
    endgenerate

    assign en      = !cnt_en_n;
    assign ptr_inc = c_q.ptr + 1'b1;

    always_comb begin
        c_d       = c_q;
        c_d.flags = (c_q.flags & flag_keep) | hit;
        if (ld || strt1 || strt2) begin
            c_d.stopped = 1'b0;
            c_d.arm     = 1'b0;
            if (ld) begin
                c_d.ptr = ld_addr;
            end else if (strt1) begin
                c_d.ptr = win_start[0];
            end else begin
                c_d.ptr = win_start[1];
            end
        end else if (c_q.stopped) begin
            if (c_q.arm) begin
                c_d.arm = 1'b0;
                if (en) begin
                    c_d.stopped = 1'b0;
                    c_d.ptr     = ptr_inc;
                end
            end else begin
                c_d.arm = rel_req;
            end
        end else if (|stop_hit) begin
            c_d.stopped = 1'b1;
            if (en) begin
                c_d.ptr = ptr_inc;
            end
        end else if (en) begin
            if (&chain_hit) begin
                c_d.ptr = win_start[0];
            end else if (chain_hit[0]) begin
                c_d.ptr = win_start[1];
            end else if (chain_hit[1]) begin
                c_d.ptr = win_start[0];
            end else begin
                c_d.ptr = ptr_inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign ptr     = c_q.ptr;
    assign flags   = c_q.flags;
    assign stopped = c_q.stopped;
endmodule

// File: rtl/seq_ptr_ctrl.sv
module seq_ptr_ctrl
    import seq_ptr_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en_n,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              strt1,
    input  logic              strt2,
    input  logic              reg_we,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0] ptr,
    output logic              eob1_n,
    output logic              eob2_n,
    output logic              wr_inhibit
);
    logic [NBUF-1:0][ADDR_W-1:0] win_start;
    logic [NBUF-1:0][ADDR_W-1:0] win_end;
    logic [NBUF-1:0][POL_W-1:0]  pol;
    logic [NBUF-1:0]             flag_keep;
    logic                        rel_req;
    logic [NBUF-1:0]             flags;
    logic                        stopped;
    logic [NBUF-1:0]             eob_n;

    seq_ptr_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .win_start (win_start),
        .win_end   (win_end),
        .pol       (pol),
        .flag_keep (flag_keep),
        .rel_req   (rel_req)
    );

    seq_ptr_core #(.ADDR_W(ADDR_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en_n  (cnt_en_n),
        .ld        (ld),
        .ld_addr   (ld_addr),
        .strt1     (strt1),
        .strt2     (strt2),
        .win_start (win_start),
        .win_end   (win_end),
        .pol       (pol),
        .flag_keep (flag_keep),
        .rel_req   (rel_req),
        .ptr       (ptr),
        .flags     (flags),
        .stopped   (stopped)
    );

    generate
        for (genvar g = 0; g < NBUF; g++) begin : g_eob
            assign eob_n[g] = !(flags[g] && (pol[g] != POL_MASK));
        end
    endgenerate

    assign eob1_n     = eob_n[0];
    assign eob2_n     = eob_n[1];
    assign wr_inhibit = stopped;

    always_comb begin
        unique case (reg_sel)
            SEL_START1: reg_rdata = win_start[0];
            SEL_END1:   reg_rdata = win_end[0];
            SEL_START2: reg_rdata = win_start[1];
            SEL_END2:   reg_rdata = win_end[1];
            SEL_FLOW:   reg_rdata = ADDR_W'({stopped, pol[1], pol[0]});
            SEL_FLAG:   reg_rdata = ADDR_W'(flags);
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/seq_ptr_ctrl_chk.sv
module seq_ptr_ctrl_chk
    import seq_ptr_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cnt_en_n,
    input logic                        ld,
    input logic [ADDR_W-1:0]           ld_addr,
    input logic                        strt1,
    input logic                        strt2,
    input logic                        reg_we,
    input logic [SEL_W-1:0]            reg_sel,
    input logic [ADDR_W-1:0]           reg_wdata,
    input logic [ADDR_W-1:0]           ptr,
    input logic                        eob1_n,
    input logic                        wr_inhibit,
    input logic [NBUF-1:0]             flags,
    input logic [NBUF-1:0][ADDR_W-1:0] win_start,
    input logic [NBUF-1:0][ADDR_W-1:0] win_end,
    input logic [NBUF-1:0][POL_W-1:0]  pol
);
    logic quiet;
    assign quiet = !ld && !strt1 && !strt2;

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en_n && quiet |=> $stable(ptr));

    // R2
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en_n && quiet && !wr_inhibit && ptr != win_end[0] && ptr != win_end[1]
        |=> ptr == ADDR_W'($past(ptr) + 1'b1));

    // R3
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> ptr == $past(ld_addr));

    // R8
    chain_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en_n && quiet && !wr_inhibit && ptr == win_end[0] && ptr != win_end[1]
        && pol[0] == POL_CHAIN |=> ptr == $past(win_start[1]));

    // R9
    stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quiet && !wr_inhibit && ptr == win_end[0] && pol[0] == POL_STOP |=> wr_inhibit);

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags[0] && !(reg_we && reg_sel == SEL_FLAG && !reg_wdata[0]) |=> flags[0]);

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && reg_sel == SEL_FLAG && !reg_wdata[0] && ptr != win_end[0] |=> !flags[0]);

    // R7
    mask_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pol[0] == POL_MASK |-> eob1_n);
endmodule

bind seq_ptr_ctrl seq_ptr_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_en_n   (cnt_en_n),
    .ld         (ld),
    .ld_addr    (ld_addr),
    .strt1      (strt1),
    .strt2      (strt2),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .ptr        (ptr),
    .eob1_n     (eob1_n),
    .wr_inhibit (wr_inhibit),
    .flags      (flags),
    .win_start  (win_start),
    .win_end    (win_end),
    .pol        (pol)
);

// File: tb/seq_ptr_ctrl_test.sv
module seq_ptr_ctrl_test;
    localparam int AW = 13;
    localparam int MOD = 8192;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnt_en_n = 1'b1;
    logic          ld = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic          strt1 = 1'b0;
    logic          strt2 = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_sel = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic [AW-1:0] ptr;
    logic          eob1_n;
    logic          eob2_n;
    logic          wr_inhibit;

    int n_tests = 0;
    int n_fail  = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    // behavioural reference state
    int m_ptr, m_stop, m_arm;
    int m_st[2];
    int m_en[2];
    int m_pol[2];
    int m_flag[2];

    always #4 clk = ~clk;

    seq_ptr_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cnt_en_n(cnt_en_n), .ld(ld), .ld_addr(ld_addr),
        .strt1(strt1), .strt2(strt2), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ptr(ptr), .eob1_n(eob1_n),
        .eob2_n(eob2_n), .wr_inhibit(wr_inhibit)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_rdata(input int sel);
        case (sel)
            0: return m_st[0];
            1: return m_en[0];
            2: return m_st[1];
            3: return m_en[1];
            4: return m_stop * 16 + m_pol[1] * 4 + m_pol[0];
            5: return m_flag[1] * 2 + m_flag[0];
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ptr = 0; m_stop = 0; m_arm = 0;
            for (int i = 0; i < 2; i++) begin
                m_st[i] = 0; m_en[i] = MOD - 1; m_pol[i] = 2; m_flag[i] = 0;
            end
        end else begin
            int np, ns, na, nxt;
            bit en, rel, any_stop, c0, c1;
            int nf[2];
            en  = !cnt_en_n;
            rel = reg_we && reg_sel == 4 && !reg_wdata[4];
            nxt = (m_ptr + 1) % MOD;
            for (int i = 0; i < 2; i++) begin
                int keep;
                keep = (reg_we && reg_sel == 5) ? int'(reg_wdata[i]) : 1;
                nf[i] = (m_flag[i] & keep) | int'(m_ptr == m_en[i]);
            end
            any_stop = (m_ptr == m_en[0] && m_pol[0] == 1) || (m_ptr == m_en[1] && m_pol[1] == 1);
            c0 = m_ptr == m_en[0] && m_pol[0] == 0;
            c1 = m_ptr == m_en[1] && m_pol[1] == 0;
            np = m_ptr; ns = m_stop; na = m_arm;
            if (ld)         begin np = int'(ld_addr); ns = 0; na = 0; end
            else if (strt1) begin np = m_st[0]; ns = 0; na = 0; end
            else if (strt2) begin np = m_st[1]; ns = 0; na = 0; end
            else if (m_stop != 0) begin
                if (m_arm != 0) begin
                    na = 0;
                    if (en) begin ns = 0; np = nxt; end
                end else na = int'(rel);
            end else if (any_stop) begin
                ns = 1;
                if (en) np = nxt;
            end else if (en) begin
                if (c0 && c1) np = m_st[0];
                else if (c0)  np = m_st[1];
                else if (c1)  np = m_st[0];
                else          np = nxt;
            end
            if (reg_we) begin
                if (reg_sel == 0) m_st[0] = int'(reg_wdata);
                if (reg_sel == 1) m_en[0] = int'(reg_wdata);
                if (reg_sel == 2) m_st[1] = int'(reg_wdata);
                if (reg_sel == 3) m_en[1] = int'(reg_wdata);
                if (reg_sel == 4) begin m_pol[0] = int'(reg_wdata[1:0]); m_pol[1] = int'(reg_wdata[3:2]); end
            end
            m_ptr = np; m_stop = ns; m_arm = na;
            m_flag[0] = nf[0]; m_flag[1] = nf[1];
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            check(cur_req, "ptr", int'(ptr), m_ptr);
            check(cur_req, "wr_inhibit", int'(wr_inhibit), m_stop);
            check(cur_req, "eob1_n", int'(eob1_n), (m_flag[0] == 1 && m_pol[0] != 3) ? 0 : 1);
            check(cur_req, "eob2_n", int'(eob2_n), (m_flag[1] == 1 && m_pol[1] != 3) ? 0 : 1);
            check(cur_req, "reg_rdata", int'(reg_rdata), exp_rdata(int'(reg_sel)));
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic wr(input int sel, input int data);
        reg_we = 1'b1; reg_sel = 3'(sel); reg_wdata = AW'(data);
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input string req, input int sel, input int exp);
        reg_sel = 3'(sel);
        #1;
        check(req, "readback", int'(reg_rdata), exp);
    endtask

    initial begin
        tick(3);
        // R1 reset state
        check("R1", "ptr", int'(ptr), 0);
        check("R1", "eob1_n", int'(eob1_n), 1);
        check("R1", "wr_inhibit", int'(wr_inhibit), 0);
        rd("R1", 4, 'h00A);
        rd("R1", 1, 'h1FFF);
        rd("R1", 5, 0);
        rst_n = 1'b1;

        // R2 counting and holding
        cur_req = "R2";
        cnt_en_n = 1'b0; tick(10);
        cnt_en_n = 1'b1; tick(3);
        check("R2", "ptr after 10 steps", int'(ptr), 10);

        // R4 register map
        cur_req = "R4";
        wr(0, 'h100); wr(1, 'h105); wr(2, 'h200); wr(3, 'h203);
        rd("R4", 0, 'h100); rd("R4", 1, 'h105); rd("R4", 2, 'h200); rd("R4", 3, 'h203);
        rd("R4", 7, 0);

        // R8 chaining both windows
        cur_req = "R8";
        wr(4, 'h10);
        strt1 = 1'b1; tick(); strt1 = 1'b0;
        cnt_en_n = 1'b0; tick(5);
        check("R8", "at end1", int'(ptr), 'h105);
        tick();
        check("R8", "jump to start2", int'(ptr), 'h200);
        tick(4);
        check("R8", "jump to start1", int'(ptr), 'h100);
        cnt_en_n = 1'b1;
        // R7 / R5 ends reported
        check("R7", "eob1_n low", int'(eob1_n), 0);
        check("R5", "eob2_n low", int'(eob2_n), 0);

        // R6 flag clearing
        cur_req = "R6";
        ld_addr = 'h50; ld = 1'b1; tick(); ld = 1'b0;
        wr(5, 'h2);
        rd("R6", 5, 2);
        wr(5, 'h1);
        rd("R6", 5, 0);

        // R8 equal ends under chaining
        cur_req = "R8";
        wr(3, 'h105);
        strt1 = 1'b1; tick(); strt1 = 1'b0;
        cnt_en_n = 1'b0; tick(6);
        check("R8", "equal ends go to start1", int'(ptr), 'h100);
        rd("R5", 5, 3);
        cnt_en_n = 1'b1;
        wr(3, 'h203);

        // R11 mask window 1, linear window 2
        cur_req = "R11";
        wr(4, 'hB); wr(5, 0);
        strt1 = 1'b1; tick(); strt1 = 1'b0;
        cnt_en_n = 1'b0; tick(8);
        cnt_en_n = 1'b1;
        check("R11", "kept counting", int'(ptr), 'h108);
        check("R7", "masked eob1_n high", int'(eob1_n), 1);
        rd("R11", 5, 1);

        // R9 stop at end+1
        cur_req = "R9";
        wr(4, 'h9);
        strt1 = 1'b1; tick(); strt1 = 1'b0;
        cnt_en_n = 1'b0; tick(6);
        check("R9", "frozen at end+1", int'(ptr), 'h106);
        tick(4);
        check("R9", "still frozen", int'(ptr), 'h106);
        check("R9", "wr_inhibit", int'(wr_inhibit), 1);
        rd("R4", 4, 'h19);

        // R10 release with enable high: stays frozen
        cur_req = "R10";
        wr(4, 'h19);
        cnt_en_n = 1'b0; tick(3);
        check("R10", "bit4=1 no release", int'(wr_inhibit), 1);
        cnt_en_n = 1'b1;
        wr(4, 'h9);
        tick();
        check("R10", "release spent without enable", int'(wr_inhibit), 1);
        cnt_en_n = 1'b0;
        tick(2);
        check("R10", "still frozen after spent release", int'(ptr), 'h106);
        wr(4, 'h9);
        tick();
        check("R10", "released to end+2", int'(ptr), 'h107);
        check("R10", "wr_inhibit low", int'(wr_inhibit), 0);

        // R9 stop at the end address itself
        cur_req = "R9";
        cnt_en_n = 1'b1;
        strt1 = 1'b1; tick(); strt1 = 1'b0;
        cnt_en_n = 1'b0; tick(5);
        cnt_en_n = 1'b1; tick();
        check("R9", "frozen at end", int'(ptr), 'h105);
        check("R9", "wr_inhibit", int'(wr_inhibit), 1);
        cur_req = "R10";
        strt2 = 1'b1; tick(); strt2 = 1'b0;
        check("R10", "start strobe releases", int'(ptr), 'h200);
        check("R10", "wr_inhibit low", int'(wr_inhibit), 0);

        // R3 priorities
        cur_req = "R3";
        wr(4, 'hA);
        ld_addr = 'h777; ld = 1'b1; strt1 = 1'b1; strt2 = 1'b1; tick();
        ld = 1'b0;
        check("R3", "ld wins", int'(ptr), 'h777);
        tick(); strt1 = 1'b0; strt2 = 1'b0;
        check("R3", "strt1 over strt2", int'(ptr), 'h100);

        // R2 wrap
        cur_req = "R2";
        ld_addr = 'h1FFE; ld = 1'b1; tick(); ld = 1'b0;
        cnt_en_n = 1'b0; tick(3); cnt_en_n = 1'b1;
        check("R2", "wrap", int'(ptr), 1);

        tick(2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule